// File: doc/BRIEF.md
# Command-Stream Packet Parser

This block sits behind a command-word fetch stage and turns a flat stream of 32-bit words into events. Words arrive on a valid/ready input, one per accepted beat. The first word of each packet is a header. The parser reads the packet type from the header's top bits, checks the protection bits that the newer header formats carry, and then counts off the payload words that follow.

Register-write packets become a sequence of write events. Each event carries a register address equal to the start index plus the payload position. Opcode packets first produce one opcode event and then one argument event per payload word, each tagged with its position. No-op words produce nothing. A header with a bad protection bit, or with an unknown type, pulses an error output and is discarded. The following word is then parsed as a fresh header.

All events leave through one registered output channel with a kind tag. That channel is held until the downstream side accepts it. Executing opcodes, fetching memory and managing ring pointers are left to other blocks.

Top module: `cmdstream_parser`

## Requirements
- R1: A legacy register-write header (bits 31:30 = 2'b00) carries the start index in bits 14:0 and the payload count minus one in bits 29:16. Each payload word yields one event with kind 0, address = start + position (mod 2^18), data = the word, and index = the position starting at 0.
- R2: A legacy opcode header (bits 31:30 = 2'b11) carries the opcode in bits 15:8 and the payload count minus one in bits 29:16. It yields one event with kind 1, data = the zero-extended opcode, index = the payload count and address 0. Each payload word then yields an event with kind 2, data = the word, index = its position and address 0.
- R3: A no-op word (bits 31:30 = 2'b10) is a whole packet by itself. It yields no event and no error.
- R4: A newer register-write header (bits 31:28 = 4'h4) carries a raw payload count in bits 6:0, its protection bit in bit 7, the start index in bits 25:8 and that index's protection bit in bit 27. Its payload events follow R1. A count of 0 is a complete packet with no event.
- R5: A newer opcode header (bits 31:28 = 4'h7) carries a raw payload count in bits 14:0, its protection bit in bit 15, the opcode in bits 22:16 and the opcode's protection bit in bit 23. Its events follow R2. A count of 0 is a complete packet with only the opcode event.
- R6: A protection bit is correct when the field plus that bit has an odd number of ones. If either check of an R4 or R5 header fails, errPulse is high for one cycle, no event is produced, and the next word is parsed as a header.
- R7: Any other header pattern (bits 31:30 = 2'b01 with bits 31:28 neither 4'h4 nor 4'h7) pulses errPulse for one cycle, yields no event, and the next word is parsed as a header.
- R8: While outValid is high and outReady is low, all output fields stay stable and no input word is accepted. inReady is high whenever the output register is empty or being drained.
- R9: While rstN is low, outValid and errPulse are low and the parser waits for a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Command word offered |
| inData | input | 32 | Command word |
| inReady | output | 1 | Word accepted on this edge when inValid is high |
| outValid | output | 1 | Event present |
| outReady | input | 1 | Downstream takes the event |
| outKind | output | 2 | 0 register write, 1 opcode, 2 argument |
| outAddr | output | 18 | Register address (register writes only) |
| outData | output | 32 | Payload word or opcode |
| outIndex | output | 15 | Payload position, or payload count for an opcode event |
| errPulse | output | 1 | One-cycle pulse per rejected header |

## Verification
The bench builds the block with its default widths: an 18-bit address and a 15-bit count. With these widths, a start index near the top of the address space makes the address wrap within a few payload words. The same widths allow a full 127-word newer register packet and a zero-length newer opcode packet. Random downstream stalls test the hold behaviour while corrupted protection bits and unknown headers are mixed into valid traffic.

// File: rtl/cmdp_pkg.sv
`timescale 1ns/1ps
package cmdp_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 18;
  localparam int CNT_W  = 15;

  typedef enum logic [1:0] {
    EV_REG = 2'd0,
    EV_OPC = 2'd1,
    EV_ARG = 2'd2
  } evKind_t;

  // strobes from control to datapath, all already qualified by accept
  typedef struct packed {
    logic accept;
    logic loadBase0;
    logic loadBase4;
    logic emitOp3;
    logic emitOp7;
    logic emitReg;
    logic emitArg;
    logic flagErr;
  } ctrlStrobe_t;
endpackage

// File: rtl/cmdp_ctrl.sv
`timescale 1ns/1ps
module cmdp_ctrl
  import cmdp_pkg::*;
#(
  parameter int CNT_W = cmdp_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [31:0]       inData,
  input  logic              inReady,
  output ctrlStrobe_t       strb,
  output logic [CNT_W-1:0]  hdrCount
);
  typedef enum logic {ST_HDR, ST_PAY} state_t;

  state_t           state;
  logic [CNT_W-1:0] remaining;
  logic             regPkt;
  logic             goPay;
  logic             nextReg;

  logic isT0, isT2, isT3, isT4, isT7;
  logic par4Ok, par7Ok;
  logic [CNT_W-1:0] cntLegacy, cnt4, cnt7;
  logic unusedHdrBit;

  assign isT0 = inData[31:30] == 2'b00;
  assign isT2 = inData[31:30] == 2'b10;
  assign isT3 = inData[31:30] == 2'b11;
  assign isT4 = inData[31:28] == 4'h4;
  assign isT7 = inData[31:28] == 4'h7;

  // odd weight of field plus protection bit
  assign par4Ok = (^inData[7:0]) & (^{inData[27], inData[25:8]});
  assign par7Ok = (^inData[15:0]) & (^inData[23:16]);

  assign cntLegacy = CNT_W'(inData[29:16]) + CNT_W'(1);
  assign cnt4      = CNT_W'(inData[6:0]);
  assign cnt7      = CNT_W'(inData[14:0]);
  assign unusedHdrBit = inData[26];

  always_comb begin
    strb        = '0;
    hdrCount    = '0;
    goPay       = 1'b0;
    nextReg     = 1'b0;
    strb.accept = inValid && inReady;
    if (strb.accept) begin
      if (state == ST_HDR) begin
        if (isT0) begin
          strb.loadBase0 = 1'b1;
          hdrCount       = cntLegacy;
          goPay          = 1'b1;
          nextReg        = 1'b1;
        end else if (isT2) begin
          goPay = 1'b0;
        end else if (isT3) begin
          strb.emitOp3 = 1'b1;
          hdrCount     = cntLegacy;
          goPay        = 1'b1;
        end else if (isT4 && par4Ok) begin
          strb.loadBase4 = 1'b1;
          hdrCount       = cnt4;
          goPay          = cnt4 != '0;
          nextReg        = 1'b1;
        end else if (isT7 && par7Ok) begin
          strb.emitOp7 = 1'b1;
          hdrCount     = cnt7;
          goPay        = cnt7 != '0;
        end else begin
          strb.flagErr = 1'b1;
        end
      end else begin
        strb.emitReg = regPkt;
        strb.emitArg = !regPkt;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_HDR;
      remaining <= '0;
      regPkt    <= 1'b0;
    end else if (strb.accept) begin
      if (state == ST_HDR) begin
        if (goPay) begin
          state     <= ST_PAY;
          remaining <= hdrCount;
          regPkt    <= nextReg;
        end
      end else begin
        remaining <= remaining - CNT_W'(1);
        if (remaining == CNT_W'(1)) state <= ST_HDR;
      end
    end
  end
endmodule

// File: rtl/cmdp_datapath.sv
`timescale 1ns/1ps
module cmdp_datapath
  import cmdp_pkg::*;
#(
  parameter int ADDR_W = cmdp_pkg::ADDR_W,
  parameter int CNT_W  = cmdp_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [CNT_W-1:0]  hdrCount,
  input  logic [31:0]       inData,
  input  logic              outReady,
  output logic              inReady,
  output logic              outValid,
  output logic [1:0]        outKind,
  output logic [ADDR_W-1:0] outAddr,
  output logic [31:0]       outData,
  output logic [CNT_W-1:0]  outIndex,
  output logic              errPulse
);
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  pos;
  logic              produce;

  assign produce = strb.emitReg | strb.emitArg | strb.emitOp3 | strb.emitOp7;
  assign inReady = !outValid || outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      base <= '0;
      pos  <= '0;
    end else begin
      if (strb.loadBase0) begin
        base <= ADDR_W'(inData[14:0]);
        pos  <= '0;
      end else if (strb.loadBase4) begin
        base <= ADDR_W'(inData[25:8]);
        pos  <= '0;
      end else if (strb.emitOp3 || strb.emitOp7) begin
        pos <= '0;
      end else if (strb.emitReg || strb.emitArg) begin
        pos <= pos + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outKind  <= EV_REG;
      outAddr  <= '0;
      outData  <= '0;
      outIndex <= '0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= strb.flagErr;
      if (produce) begin
        outValid <= 1'b1;
        outAddr  <= '0;
        outIndex <= pos;
        outData  <= inData;
        if (strb.emitReg) begin
          outKind <= EV_REG;
          outAddr <= base + ADDR_W'(pos);
        end else if (strb.emitArg) begin
          outKind <= EV_ARG;
        end else begin
          outKind  <= EV_OPC;
          outIndex <= hdrCount;
          outData  <= strb.emitOp3 ? {24'd0, inData[15:8]} : {25'd0, inData[22:16]};
        end
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmdstream_parser.sv
`timescale 1ns/1ps
module cmdstream_parser
  import cmdp_pkg::*;
#(
  parameter int ADDR_W = cmdp_pkg::ADDR_W,
  parameter int CNT_W  = cmdp_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [31:0]       inData,
  output logic              inReady,
  output logic              outValid,
  input  logic              outReady,
  output logic [1:0]        outKind,
  output logic [ADDR_W-1:0] outAddr,
  output logic [31:0]       outData,
  output logic [CNT_W-1:0]  outIndex,
  output logic              errPulse
);
  ctrlStrobe_t      strb;
  logic [CNT_W-1:0] hdrCount;

  cmdp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inData   (inData),
    .inReady  (inReady),
    .strb     (strb),
    .hdrCount (hdrCount)
  );

  cmdp_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .hdrCount (hdrCount),
    .inData   (inData),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .outKind  (outKind),
    .outAddr  (outAddr),
    .outData  (outData),
    .outIndex (outIndex),
    .errPulse (errPulse)
  );
endmodule

// File: rtl/cmdp_checker.sv
`timescale 1ns/1ps
module cmdp_checker #(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [1:0]        outKind,
  input logic [ADDR_W-1:0] outAddr,
  input logic [31:0]       outData,
  input logic [CNT_W-1:0]  outIndex,
  input logic              errPulse
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable({outKind, outAddr, outData, outIndex})));

  assert_new_event_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid && inReady));

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(inValid && inReady));

  assert_kind_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outKind != 2'd3));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rstN |=> (!outValid && !errPulse));
endmodule

bind cmdstream_parser cmdp_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outKind  (outKind),
  .outAddr  (outAddr),
  .outData  (outData),
  .outIndex (outIndex),
  .errPulse (errPulse)
);

// File: tb/sim_cmdstream_parser.sv
`timescale 1ns/1ps
module sim_cmdstream_parser;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        inReady;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [1:0]  outKind;
  logic [17:0] outAddr;
  logic [31:0] outData;
  logic [14:0] outIndex;
  logic        errPulse;

  int total = 0;
  int bad = 0;
  int errExp = 0;
  int errSeen = 0;
  bit running = 1'b0;
  bit readyAlways = 1'b0;

  typedef struct {
    logic [1:0]  k;
    logic [17:0] a;
    logic [31:0] d;
    logic [14:0] x;
  } ev_t;
  ev_t expQ[$];

  always #2 clk = ~clk;

  cmdstream_parser u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outKind(outKind), .outAddr(outAddr),
    .outData(outData), .outIndex(outIndex), .errPulse(errPulse)
  );

  function automatic logic prot(input logic [31:0] v);
    logic [3:0] f;
    f = v[3:0] ^ v[7:4] ^ v[11:8] ^ v[15:12] ^ v[19:16] ^ v[23:20] ^ v[27:24] ^ v[31:28];
    return logic'((32'h9669 >> f) & 32'd1);
  endfunction

  function automatic logic [31:0] hdrT0(input logic [14:0] r, input int cnt);
    return {2'b00, 14'(cnt - 1), 1'b0, r};
  endfunction
  function automatic logic [31:0] hdrT3(input logic [7:0] op, input int cnt);
    return {2'b11, 14'(cnt - 1), op, 8'h00};
  endfunction
  function automatic logic [31:0] hdrT4(input logic [17:0] r, input int cnt);
    return {4'h4, prot(32'(r)), 1'b0, r, prot(32'(cnt)), 7'(cnt)};
  endfunction
  function automatic logic [31:0] hdrT7(input logic [6:0] op, input int cnt);
    return {4'h7, 4'h0, prot(32'(op)), op, prot(32'(cnt)), 15'(cnt)};
  endfunction

  task automatic check(input bit ok, input string req, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  task automatic sendWord(input logic [31:0] w);
    @(negedge clk); #1;
    inValid = 1'b1;
    inData  = w;
    while (!inReady) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    #0.5;
    inValid = 1'b0;
  endtask

  task automatic pushEv(input logic [1:0] k, input logic [17:0] a, input logic [31:0] d, input logic [14:0] x);
    ev_t e;
    e.k = k; e.a = a; e.d = d; e.x = x;
    expQ.push_back(e);
  endtask

  task automatic pktReg(input bit newer, input logic [17:0] r, input int cnt);
    logic [31:0] d;
    sendWord(newer ? hdrT4(r, cnt) : hdrT0(r[14:0], cnt));
    for (int i = 0; i < cnt; i++) begin
      d = $urandom;
      pushEv(2'd0, 18'(r + 18'(i)), d, 15'(i));
      sendWord(d);
    end
  endtask

  task automatic pktOp(input bit newer, input logic [7:0] op, input int cnt);
    logic [31:0] d;
    pushEv(2'd1, 18'd0, newer ? {25'd0, op[6:0]} : {24'd0, op}, 15'(cnt));
    sendWord(newer ? hdrT7(op[6:0], cnt) : hdrT3(op, cnt));
    for (int i = 0; i < cnt; i++) begin
      d = $urandom;
      pushEv(2'd2, 18'd0, d, 15'(i));
      sendWord(d);
    end
  endtask

  task automatic badWord(input logic [31:0] w);
    errExp++;
    sendWord(w);
  endtask

  // monitor: drive ready, compare transfers, check hold behaviour
  bit holdPending = 1'b0;
  ev_t snap;
  always @(negedge clk) begin
    if (running) begin
      if (holdPending) begin
        check(outValid && outKind == snap.k && outAddr == snap.a && outData == snap.d && outIndex == snap.x,
              "R8", $sformatf("held event changed: got k=%0d a=%h d=%h x=%0d exp k=%0d a=%h d=%h x=%0d",
              outKind, outAddr, outData, outIndex, snap.k, snap.a, snap.d, snap.x));
      end
      outReady = readyAlways ? 1'b1 : (($urandom % 4) != 0);
      if (errPulse) errSeen++;
      holdPending = outValid && !outReady;
      if (holdPending) begin
        snap.k = outKind; snap.a = outAddr; snap.d = outData; snap.x = outIndex;
      end
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3", $sformatf("unexpected event k=%0d d=%h, expected none", outKind, outData));
        end else begin
          ev_t e;
          e = expQ.pop_front();
          check(outKind == e.k && outAddr == e.a && outData == e.d && outIndex == e.x,
                (e.k == 2'd0) ? "R1/R4" : "R2/R5",
                $sformatf("event got k=%0d a=%h d=%h x=%0d exp k=%0d a=%h d=%h x=%0d",
                outKind, outAddr, outData, outIndex, e.k, e.a, e.d, e.x));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired: got hung run, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seedDummy;
    int kind;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!outValid && !errPulse && inReady, "R9",
          $sformatf("reset state got v=%0d e=%0d r=%0d exp 0 0 1", outValid, errPulse, inReady));
    rstN = 1'b1;
    running = 1'b1;

    // directed corners
    pktReg(1'b0, 18'h7FFE, 3);           // R1 address past 15-bit start range
    pktReg(1'b1, 18'h3FFFF, 2);          // R4 address wrap
    pktReg(1'b1, 18'h00123, 127);        // R4 largest count
    pktReg(1'b1, 18'h00055, 0);          // R4 empty packet
    sendWord(32'h8000_0000);             // R3 no-op
    pktOp(1'b1, 8'h5A, 0);               // R5 zero count
    pktOp(1'b0, 8'hE7, 2);               // R2
    badWord(hdrT4(18'h00010, 2) ^ 32'h0800_0000);   // R6 index protection flipped
    pktReg(1'b0, 18'h00020, 1);
    badWord(hdrT7(7'h11, 3) ^ 32'h0000_8000);       // R6 count protection flipped
    badWord(hdrT4(18'h00001, 1) ^ 32'h0000_0080);   // R6 back to back
    pktOp(1'b1, 8'h22, 1);
    badWord(32'h5123_4567);                         // R7 unknown
    pktOp(1'b0, 8'h01, 1);

    // random traffic
    for (int p = 0; p < 400; p++) begin
      kind = $urandom % 20;
      if (kind < 4)       pktReg(1'b0, 18'($urandom % 32768), 1 + ($urandom % 6));
      else if (kind < 8)  pktOp(1'b0, 8'($urandom), 1 + ($urandom % 5));
      else if (kind < 10) sendWord(32'h8000_0000 | ($urandom & 32'h3FFF_FFFF));
      else if (kind < 14) pktReg(1'b1, 18'($urandom), $urandom % 7);
      else if (kind < 18) pktOp(1'b1, 8'($urandom), $urandom % 6);
      else if (kind < 19) badWord(hdrT7(7'($urandom), $urandom % 4) ^ (32'h1 << (($urandom % 2) ? 15 : 23)));
      else                badWord(32'h5000_0000 | ($urandom & 32'h0FFF_FFFF));
    end

    readyAlways = 1'b1;
    for (int w = 0; w < 2000 && expQ.size() != 0; w++) @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(expQ.size() == 0, "R1", $sformatf("events outstanding got %0d exp 0", expQ.size()));
    check(errSeen == errExp, "R6/R7", $sformatf("error pulses got %0d exp %0d", errSeen, errExp));
    check(!outValid && inReady, "R8", $sformatf("idle got v=%0d r=%0d exp 0 1", outValid, inReady));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule